// File: doc/BRIEF.md
# Modem Interface Status Tracker

This block keeps the 16-bit status word of a serial CODEC/modem link. A CPU reads the word through a one-cycle read strobe. Surrounding logic reports events as single-cycle strobes: receive overrun, transmit underrun, interrupt request, transmitted and received words, timer ticks and a start command. The block turns these strobes into status bits.

Three event bits are sticky and clear when the CPU reads them. A timeout counter advances while a transfer is waiting and raises a timeout bit at a programmable limit. A configuration-complete bit rises once a fixed number of 16-bit words has been sent after a start command. Two front-end select lines and a byte-mode line are copied into the word at the time of the read. The FIFO, the shifter and the interrupt controller stay outside the block.

Top module: `modem_status_tracker`

## Requirements
- R1: Bits 15:8 of `rd_data_o` always read 0.
- R2: Bits 7:6 of the read word carry `fe_sel_i` and bit 5 carries `byte_mode_i`. Both are sampled in the cycle of the read strobe, with no latching beyond the read register.
- R3: A read strobe in cycle t loads `rd_data_o`, and the new value is visible from cycle t+1. The value holds until the next read strobe. It shows the flag values from before the read clears them.
- R4: Bit 1 (receive overrun) is set by `rx_ovr_i` and bit 0 (transmit underrun) is set by `tx_udr_i`. Each stays set until a read clears it. When an event and a read fall in the same cycle, the flag stays set.
- R5: Bit 2 (pending interrupt) is set by `irq_req_i` and is driven on `irq_o`. A read clears it, with the same set-wins rule as R4.
- R6: After a start command, the CFG_WORDS-th `tx_word_i` strobe (9 by default) sets bit 3 (configuration complete) in the following cycle. Further words leave it set. A new start clears it and restarts the count.
- R7: Bit 4 (timeout) is set when the timeout count, which advances on `tick_i` while `xfer_wait_i` is high, reaches `tmo_limit_i`. Any `tx_word_i` or `rx_word_i` clears the count. The flag holds until the next start. A limit of 0 never times out, and the count saturates at its maximum value.
- R8: After reset, `rd_data_o` is 0, `irq_o` is 0, and bits 4:0 read 0.
- R9: Word strobes seen before the first start are not counted. A word in the same cycle as a start is not counted either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command (FIFO pointer reset) pulse |
| tx_word_i | input | 1 | One 16-bit word transmitted |
| rx_word_i | input | 1 | One 16-bit word received |
| xfer_wait_i | input | 1 | A transfer is waiting |
| tick_i | input | 1 | Timeout enable tick |
| tmo_limit_i | input | TMO_W | Timeout count limit |
| rx_ovr_i | input | 1 | Receive overrun event |
| tx_udr_i | input | 1 | Transmit underrun event |
| irq_req_i | input | 1 | Interrupt request event |
| fe_sel_i | input | 2 | Front-end select lines |
| byte_mode_i | input | 1 | Byte-mode line |
| rd_i | input | 1 | Status read strobe |
| rd_data_o | output | 16 | Registered status word |
| irq_o | output | 1 | Pending interrupt |

## Verification
The bench builds the block with TMO_W = 4 and the default CFG_WORDS = 9. With a 4-bit counter, the timeout limit can be hit both early and at its top value of 15 within a few dozen ticks, so random limits regularly produce timeouts and the saturation rule comes into play. The nine-word configuration count stays at its real length. Random start commands then fall both before the count completes and after it.

// File: rtl/mst_pkg.sv
package mst_pkg;
    localparam int STAT_W  = 16;
    localparam int NFLAGS  = 3;
    localparam int FLG_TX  = 0;
    localparam int FLG_RX  = 1;
    localparam int FLG_IRQ = 2;

    function automatic logic [STAT_W-1:0] pack_status(
        input logic [1:0]        sel,
        input logic              bmode,
        input logic              tmo,
        input logic              cfg,
        input logic [NFLAGS-1:0] flags
    );
        return {8'h00, sel, bmode, tmo, cfg, flags};
    endfunction
endpackage

// File: rtl/mst_sticky.sv
module mst_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         rd_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = set_i | (flags_q & {N{~rd_i}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R4/R5: an event sets the flag even during a read
        p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flags_q[g]);
        // R4/R5: a read with no event clears the flag
        p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_i && !set_i[g]) |=> !flags_q[g]);
    end
endmodule

// File: rtl/mst_cfg_track.sv
module mst_cfg_track #(
    parameter int CFG_WORDS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tx_word_i,
    output logic done_o
);
    localparam int CNT_W = $clog2(CFG_WORDS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CFG_WORDS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             done;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
            st_d.done  = 1'b0;
        end else if (tx_word_i && st_q.armed && st_q.cnt != LAST) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_d.cnt == LAST) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;

    p_start_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !st_q.done);
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !start_i) |=> st_q.done);
    p_unarmed_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && !start_i) |=> !st_q.done);
endmodule

// File: rtl/mst_tmo_track.sv
module mst_tmo_track #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             word_i,
    input  logic             wait_i,
    input  logic             tick_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             tmo_o
);
    typedef struct packed {
        logic [TMO_W-1:0] cnt;
        logic             flag;
    } tmo_st_t;

    tmo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
        end else if (word_i) begin
            st_d.cnt = '0;
        end else if (tick_i && wait_i && st_q.cnt != '1) begin
            st_d.cnt = st_q.cnt + TMO_W'(1);
            if (st_d.cnt == limit_i) st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmo_o = st_q.flag;

    p_tmo_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !start_i) |=> st_q.flag);
    p_word_resets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && word_i) |=> (st_q.cnt == '0));
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '1 && !start_i && !word_i) |=> (st_q.cnt == '1));
endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker #(
    parameter int CFG_WORDS = 9,
    parameter int TMO_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tx_word_i,
    input  logic             rx_word_i,
    input  logic             xfer_wait_i,
    input  logic             tick_i,
    input  logic [TMO_W-1:0] tmo_limit_i,
    input  logic             rx_ovr_i,
    input  logic             tx_udr_i,
    input  logic             irq_req_i,
    input  logic [1:0]       fe_sel_i,
    input  logic             byte_mode_i,
    input  logic             rd_i,
    output logic [15:0]      rd_data_o,
    output logic             irq_o
);
    import mst_pkg::*;

    logic [NFLAGS-1:0] ev, flags;
    logic              cfg_done, tmo_flag;
    logic [STAT_W-1:0] rd_d, rd_q;

    always_comb begin
        ev          = '0;
        ev[FLG_TX]  = tx_udr_i;
        ev[FLG_RX]  = rx_ovr_i;
        ev[FLG_IRQ] = irq_req_i;
    end

    mst_sticky #(.N(NFLAGS)) u_sticky (
        .clk(clk), .rst_n(rst_n), .set_i(ev), .rd_i(rd_i), .flags_o(flags)
    );

    mst_cfg_track #(.CFG_WORDS(CFG_WORDS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .tx_word_i(tx_word_i), .done_o(cfg_done)
    );

    mst_tmo_track #(.TMO_W(TMO_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .word_i(tx_word_i | rx_word_i), .wait_i(xfer_wait_i),
        .tick_i(tick_i), .limit_i(tmo_limit_i), .tmo_o(tmo_flag)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_i) rd_d = pack_status(fe_sel_i, byte_mode_i, tmo_flag, cfg_done, flags);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data_o = rd_q;
    assign irq_o     = flags[FLG_IRQ];

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q[15:8] == 8'h00);
    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rd_q));
    p_rd_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> (rd_q[7:5] == $past({fe_sel_i, byte_mode_i})));
endmodule

// File: tb/modem_status_tracker_tb_top.sv
module modem_status_tracker_tb_top;
    localparam int TW = 4;
    localparam int NW = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start, txw, rxw, wt, tick, rxo, txu, irq, bm, rd;
    logic [TW-1:0] lim;
    logic [1:0] sel;
    logic [15:0] rd_data;
    logic irq_o;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    modem_status_tracker #(.CFG_WORDS(NW), .TMO_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .tx_word_i(txw), .rx_word_i(rxw),
        .xfer_wait_i(wt), .tick_i(tick), .tmo_limit_i(lim), .rx_ovr_i(rxo),
        .tx_udr_i(txu), .irq_req_i(irq), .fe_sel_i(sel), .byte_mode_i(bm),
        .rd_i(rd), .rd_data_o(rd_data), .irq_o(irq_o)
    );

    // reference model built from the requirements
    logic m_rx, m_tx, m_irq, m_cfg, m_arm, m_tmo;
    int m_wc, m_tc;
    logic [15:0] m_rd;

    function automatic logic [15:0] exp_word(logic [1:0] s, logic b, logic t, logic c,
                                             logic i, logic r, logic x);
        return {8'h00, s, b, t, c, i, r, x};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_rx, m_tx, m_irq, m_cfg, m_arm, m_tmo} = '0;
            m_wc = 0; m_tc = 0; m_rd = '0;
        end else begin
            if (rd) m_rd = exp_word(sel, bm, m_tmo, m_cfg, m_irq, m_rx, m_tx);
            m_rx  = rxo | (m_rx & !rd);
            m_tx  = txu | (m_tx & !rd);
            m_irq = irq | (m_irq & !rd);
            if (start) begin
                m_wc = 0; m_cfg = 1'b0; m_arm = 1'b1;
            end else if (txw && m_arm && m_wc < NW) begin
                m_wc++;
                if (m_wc == NW) m_cfg = 1'b1;
            end
            if (start) begin
                m_tc = 0; m_tmo = 1'b0;
            end else if (txw || rxw) begin
                m_tc = 0;
            end else if (tick && wt && m_tc < (1 << TW) - 1) begin
                m_tc++;
                if (m_tc == int'(lim)) m_tmo = 1'b1;
            end
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        {start, txw, rxw, tick, rxo, txu, irq, rd} = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        clr();
    endtask

    task automatic do_read(output logic [15:0] v);
        rd = 1'b1;
        step();
        v = rd_data;
    endtask

    task automatic send_words(int n);
        for (int i = 0; i < n; i++) begin txw = 1'b1; step(); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog all-R act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd2024));
        clr(); wt = 1'b0; lim = '0; sel = 2'b00; bm = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 rd_data", rd_data, 16'h0000);
        chk("R8 irq_o", {15'h0, irq_o}, 16'h0000);
        do_read(v);
        chk("R8 flags", {11'h0, v[4:0]}, 16'h0000);
        // R1 R2 live bits and reserved zeros
        sel = 2'b10; bm = 1'b1;
        do_read(v);
        chk("R2 sel/byte", {13'h0, v[7:5]}, 16'h0005);
        chk("R1 reserved", {8'h0, v[15:8]}, 16'h0000);
        sel = 2'b01; bm = 1'b0;
        step();
        chk("R3 hold", rd_data, 16'h00A0);
        // R9 words before any start ignored
        send_words(NW);
        do_read(v);
        chk("R9 unarmed", {15'h0, v[3]}, 16'h0000);
        // R6 nine words after start
        start = 1'b1; step();
        send_words(NW - 1);
        do_read(v);
        chk("R6 eight words", {15'h0, v[3]}, 16'h0000);
        send_words(1);
        do_read(v);
        chk("R6 ninth word", {15'h0, v[3]}, 16'h0001);
        send_words(3);
        do_read(v);
        chk("R6 beyond nine", {15'h0, v[3]}, 16'h0001);
        start = 1'b1; step();
        do_read(v);
        chk("R6 restart clears", {15'h0, v[3]}, 16'h0000);
        // R9 start and word together: word not counted
        start = 1'b1; txw = 1'b1; step();
        send_words(NW - 1);
        do_read(v);
        chk("R9 same-cycle word", {15'h0, v[3]}, 16'h0000);
        send_words(1);
        do_read(v);
        chk("R9 after ninth", {15'h0, v[3]}, 16'h0001);
        // R4 sticky, clear on read, set wins
        rxo = 1'b1; step();
        do_read(v);
        chk("R4 rx set", {14'h0, v[1:0]}, 16'h0002);
        do_read(v);
        chk("R4 rx cleared", {14'h0, v[1:0]}, 16'h0000);
        txu = 1'b1; rd = 1'b1; step();
        chk("R3 pre-clear value", {14'h0, rd_data[1:0]}, 16'h0000);
        do_read(v);
        chk("R4 set wins", {14'h0, v[1:0]}, 16'h0001);
        // R5 interrupt pending
        irq = 1'b1; step();
        chk("R5 irq_o set", {15'h0, irq_o}, 16'h0001);
        do_read(v);
        chk("R5 bit2", {15'h0, v[2]}, 16'h0001);
        chk("R5 irq_o cleared", {15'h0, irq_o}, 16'h0000);
        // R7 timeout
        start = 1'b1; lim = 4'd3; wt = 1'b1; step();
        repeat (2) begin tick = 1'b1; step(); end
        rxw = 1'b1; step();
        repeat (2) begin tick = 1'b1; step(); end
        do_read(v);
        chk("R7 word resets count", {15'h0, v[4]}, 16'h0000);
        tick = 1'b1; step();
        do_read(v);
        chk("R7 limit reached", {15'h0, v[4]}, 16'h0001);
        txw = 1'b1; step();
        do_read(v);
        chk("R7 flag holds", {15'h0, v[4]}, 16'h0001);
        start = 1'b1; lim = 4'd0; step();
        repeat (20) begin tick = 1'b1; step(); end
        do_read(v);
        chk("R7 limit zero", {15'h0, v[4]}, 16'h0000);
        start = 1'b1; lim = 4'd15; step();
        repeat (20) begin tick = 1'b1; step(); end
        do_read(v);
        chk("R7 saturate at max", {15'h0, v[4]}, 16'h0001);
        // random phase against model (R1..R9)
        for (int c = 0; c < 4000; c++) begin
            logic was_rd;
            start = ($urandom % 40) == 0;
            txw   = ($urandom % 4) == 0;
            rxw   = ($urandom % 6) == 0;
            tick  = ($urandom % 2) == 0;
            wt    = ($urandom % 4) != 0;
            rxo   = ($urandom % 8) == 0;
            txu   = ($urandom % 8) == 0;
            irq   = ($urandom % 8) == 0;
            rd    = ($urandom % 4) == 0;
            sel   = 2'($urandom);
            bm    = 1'($urandom);
            if (($urandom % 64) == 0) lim = TW'($urandom);
            was_rd = rd;
            step();
            if (was_rd) chk("R3 random read", rd_data, m_rd);
            chk("R5 random irq_o", {15'h0, irq_o}, {15'h0, m_irq});
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule